// File: doc/BRIEF.md
# PCI Configuration Access Sequencer

This block performs PCI configuration reads and writes for a host bridge that has only two general memory windows toward the PCI bus. A request gives a bus number, a device/function number, a register offset, a size in bytes (1, 2 or 4) and a direction. The sequencer first widens window 0 so that it also covers the range normally served by window 1. It then points window 1 at the configuration region and sets window 1's map to configuration cycles. It makes the access through that temporary window, and finally puts window 1 back to prefetchable memory before shrinking window 0 to its normal size.

On bus 0 it builds a type-0 address. The one-hot device-select bit goes either into the local address or into the map register, depending on the slot. Other buses get a type-1 address. Every write is followed by a read-back of the same location before the windows are restored. A single busy flag holds off further requests. Read data is returned with a one-cycle done pulse, and illegal requests are refused with a one-cycle error pulse.

Top module: `cfg_access_seq`

## Requirements
- R1: After acceptance, the first three register-port writes are, in order: address code 0 (window 0 base) with 0x40000091 (512 MB, enabled), address code 1 (window 1 base) with 0x61000041 (configuration region, 16 MB, enabled), and address code 2 (window 1 map) with the map value built for the request.
- R2: After the configuration access, the last three register-port writes are, in order: code 1 with 0x50000089 (256 MB, prefetchable, enabled), code 2 with 0x0000100C (bus address 0x10000000, memory-multiple type), and code 0 with 0x40000081 (256 MB, enabled).
- R3: On bus 0 with a slot (devfn bits 7:3) of 12 or less, the built address holds the function (devfn bits 2:0) in bits 10:8 and a single device bit at bit slot+11, and the map value is 0x000A (configuration type 5 in bits 3:1, low-address enable in bit 0 clear).
- R4: On bus 0 with a slot above 12, the address holds only the function bits, and the map value is 0x000A with bit slot-5 also set. Bits past the 16-bit map width are dropped, so slots above 20 set no device bit.
- R5: On any other bus, the address holds the bus number in bits 23:16 and the devfn in bits 15:8, and the map value is 0x000B.
- R6: A write request produces a memory write carrying the request data, followed by a memory read of the same address and size. A read request produces exactly one memory read.
- R7: A request whose bus, devfn or offset exceeds 255 gives a one-cycle errPulse in the cycle after it is presented, with no register-port write, no memory access and busy held low.
- R8: busy is high from the cycle after acceptance until the last restore write; reqReady is its inverse, and a request held during busy is accepted only after the current one completes.
- R9: The memory address is 0x61000000 plus the built address plus the offset, memSize equals the request size, and address and size hold steady while an access waits for memAck.
- R10: doneValid pulses for one cycle, with busy low, in the cycle after the final restore write. rdData then holds the data of the read access, or of the read-back for a write.
- R11: After reset, busy, doneValid, errPulse, regWrEn and memValid are low and reqReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted when high together with reqValid |
| reqWrite | input | 1 | 1 = configuration write, 0 = read |
| reqBus | input | 9 | Bus number (values above 255 illegal) |
| reqDevfn | input | 9 | Device/function number (values above 255 illegal) |
| reqOffset | input | 9 | Register offset (values above 255 illegal) |
| reqSize | input | 3 | Access size in bytes (1, 2, 4) |
| reqWdata | input | 32 | Write data |
| busy | output | 1 | Sequence in progress |
| doneValid | output | 1 | One-cycle completion pulse |
| errPulse | output | 1 | One-cycle illegal-request pulse |
| rdData | output | 32 | Returned data |
| regWrEn | output | 1 | Window register write strobe |
| regWrAddr | output | 2 | 0 window 0 base, 1 window 1 base, 2 window 1 map |
| regWrData | output | 32 | Window register value |
| memValid | output | 1 | Memory access request |
| memWrite | output | 1 | Memory access is a write |
| memAddr | output | 32 | Memory access address |
| memSize | output | 3 | Memory access size in bytes |
| memWdata | output | 32 | Memory write data |
| memAck | input | 1 | Memory access completes at this edge |
| memRdata | input | 32 | Memory read data, valid with memAck |

## Verification
Counting from the accepting edge, the three opening register writes appear in cycles 1 to 3 and the access in cycle 4. With an immediate acknowledge, a read's done pulse lands in cycle 8, and a write's lands in cycle 9 because of the read-back. Each wait state the memory adds delays these by one cycle per access. An illegal request's error pulse is due in cycle 1. The bench drives requests and samples every output on the falling edge. It counts falling edges from acceptance and compares the cycle of doneValid with the exact figure above. The register writes and memory operations are logged in the cycle they occur and then compared in order with values worked out from the requirements.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OPEN_W0,
    ST_OPEN_W1BASE,
    ST_OPEN_W1MAP,
    ST_ACCESS,
    ST_READBACK,
    ST_CLOSE_W1BASE,
    ST_CLOSE_W1MAP,
    ST_CLOSE_W0
  } seqState_e;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_W0_WIDE,
    SEL_W1_CFG,
    SEL_W1_MAP_CFG,
    SEL_W1_PREF,
    SEL_W1_MAP_MEM,
    SEL_W0_NORMAL
  } regSel_e;

  typedef struct packed {
    logic    loadReq;
    logic    capRead;
    regSel_e regSel;
  } dpStrobe_t;

  localparam logic [1:0] RA_WIN0_BASE = 2'd0;
  localparam logic [1:0] RA_WIN1_BASE = 2'd1;
  localparam logic [1:0] RA_WIN1_MAP  = 2'd2;

endpackage

// File: rtl/cfgseq_ctrl.sv
module cfgseq_ctrl
  import cfgseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      reqValid,
  input  logic      reqWrite,
  input  logic      reqIllegal,
  input  logic      memAck,
  output dpStrobe_t strobe,
  output logic      regWrEn,
  output logic      memValid,
  output logic      memWrite,
  output logic      busy,
  output logic      reqReady,
  output logic      doneValid,
  output logic      errPulse
);

  seqState_e state, stateNext;
  logic      wrReq;
  logic      accept;

  assign accept = (state == ST_IDLE) && reqValid && !reqIllegal;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:         if (accept) stateNext = ST_OPEN_W0;
      ST_OPEN_W0:      stateNext = ST_OPEN_W1BASE;
      ST_OPEN_W1BASE:  stateNext = ST_OPEN_W1MAP;
      ST_OPEN_W1MAP:   stateNext = ST_ACCESS;
      ST_ACCESS:       if (memAck) stateNext = wrReq ? ST_READBACK : ST_CLOSE_W1BASE;
      ST_READBACK:     if (memAck) stateNext = ST_CLOSE_W1BASE;
      ST_CLOSE_W1BASE: stateNext = ST_CLOSE_W1MAP;
      ST_CLOSE_W1MAP:  stateNext = ST_CLOSE_W0;
      ST_CLOSE_W0:     stateNext = ST_IDLE;
      default:         stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.loadReq = accept;
    strobe.capRead = memAck && ((state == ST_ACCESS && !wrReq) || state == ST_READBACK);
    case (state)
      ST_OPEN_W0:      strobe.regSel = SEL_W0_WIDE;
      ST_OPEN_W1BASE:  strobe.regSel = SEL_W1_CFG;
      ST_OPEN_W1MAP:   strobe.regSel = SEL_W1_MAP_CFG;
      ST_CLOSE_W1BASE: strobe.regSel = SEL_W1_PREF;
      ST_CLOSE_W1MAP:  strobe.regSel = SEL_W1_MAP_MEM;
      ST_CLOSE_W0:     strobe.regSel = SEL_W0_NORMAL;
      default:         strobe.regSel = SEL_NONE;
    endcase
  end

  assign regWrEn  = (strobe.regSel != SEL_NONE);
  assign memValid = (state == ST_ACCESS) || (state == ST_READBACK);
  assign memWrite = (state == ST_ACCESS) && wrReq;
  assign busy     = (state != ST_IDLE);
  assign reqReady = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      wrReq     <= 1'b0;
      doneValid <= 1'b0;
      errPulse  <= 1'b0;
    end else begin
      state     <= stateNext;
      doneValid <= (state == ST_CLOSE_W0);
      errPulse  <= (state == ST_IDLE) && reqValid && reqIllegal;
      if (accept) wrReq <= reqWrite;
    end
  end

  // R1 / R6: register port and memory port never active together
  assert_port_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(regWrEn && memValid));

  // R10: done arrives only as busy ends
  assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |-> (!busy && $past(busy)));

  // R8: busy drops only with a completion pulse following
  assert_busy_end_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> doneValid);

  // R7: an error pulse never overlaps a running sequence
  assert_err_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    errPulse |-> (!busy && !regWrEn && !memValid));

endmodule

// File: rtl/cfgseq_dpath.sv
module cfgseq_dpath
  import cfgseq_pkg::*;
#(
  parameter int          IDX_W       = 9,
  parameter int          ADDR_W      = 32,
  parameter int          DATA_W      = 32,
  parameter int          MAP_W       = 16,
  parameter logic [31:0] CFG_BASE    = 32'h6100_0000,
  parameter logic [31:0] NONMEM_BASE = 32'h4000_0000,
  parameter logic [31:0] PREMEM_BASE = 32'h5000_0000,
  parameter logic [31:0] PREMEM_BUS  = 32'h1000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strobe,
  input  logic [IDX_W-1:0]  reqBus,
  input  logic [IDX_W-1:0]  reqDevfn,
  input  logic [IDX_W-1:0]  reqOffset,
  input  logic [2:0]        reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              reqIllegal,
  output logic [1:0]        regWrAddr,
  output logic [31:0]       regWrData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [2:0]        memSize,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [31:0] BASE_MASK  = 32'hFFF0_0000;
  localparam logic [3:0]  SZ_16M     = 4'd4;
  localparam logic [3:0]  SZ_256M    = 4'd8;
  localparam logic [3:0]  SZ_512M    = 4'd9;
  localparam logic [2:0]  TYPE_CFG   = 3'd5;
  localparam logic [2:0]  TYPE_MEMM  = 3'd6;
  localparam int          SLOT_SPLIT = 12;

  localparam logic [31:0] VAL_W0_WIDE   = (NONMEM_BASE & BASE_MASK) | {24'd0, SZ_512M, 4'b0001};
  localparam logic [31:0] VAL_W0_NORMAL = (NONMEM_BASE & BASE_MASK) | {24'd0, SZ_256M, 4'b0001};
  localparam logic [31:0] VAL_W1_CFG    = (CFG_BASE & BASE_MASK)    | {24'd0, SZ_16M,  4'b0001};
  localparam logic [31:0] VAL_W1_PREF   = (PREMEM_BASE & BASE_MASK) | {24'd0, SZ_256M, 4'b1001};
  localparam logic [15:0] VAL_MAP_MEM   = (PREMEM_BUS[31:16] & 16'hFFF0) | {12'd0, TYPE_MEMM, 1'b0};
  localparam logic [MAP_W-1:0] MAP_CFG  = MAP_W'({TYPE_CFG, 1'b0});

  logic [4:0]        slot;
  logic [2:0]        func;
  logic [31:0]       builtAddr;
  logic [MAP_W-1:0]  builtMap;
  logic [MAP_W-1:0]  mapReg;
  logic [ADDR_W-1:0] addrReg;
  logic [2:0]        sizeReg;
  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] rdReg;

  // illegal when any bit above the low byte is set in any field
  assign reqIllegal = (|reqBus[IDX_W-1:8]) || (|reqDevfn[IDX_W-1:8]) ||
                      (|reqOffset[IDX_W-1:8]);

  assign slot = reqDevfn[7:3];
  assign func = reqDevfn[2:0];

  always_comb begin
    builtAddr = '0;
    builtMap  = MAP_CFG;
    if (reqBus[7:0] == 8'd0) begin
      builtAddr[10:8] = func;
      if (int'(slot) > SLOT_SPLIT)
        builtMap = builtMap | (MAP_W'(1) << (slot - 5'd5));
      else
        builtAddr = builtAddr | (32'd1 << ({1'b0, slot} + 6'd11));
    end else begin
      builtAddr[23:16] = reqBus[7:0];
      builtAddr[15:8]  = reqDevfn[7:0];
      builtMap[0]      = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mapReg   <= '0;
      addrReg  <= '0;
      sizeReg  <= '0;
      wdataReg <= '0;
      rdReg    <= '0;
    end else begin
      if (strobe.loadReq) begin
        mapReg   <= builtMap;
        addrReg  <= ADDR_W'(CFG_BASE) + ADDR_W'(builtAddr) + ADDR_W'(reqOffset[7:0]);
        sizeReg  <= reqSize;
        wdataReg <= reqWdata;
      end
      if (strobe.capRead) rdReg <= memRdata;
    end
  end

  always_comb begin
    regWrAddr = RA_WIN0_BASE;
    regWrData = '0;
    case (strobe.regSel)
      SEL_W0_WIDE:    begin regWrAddr = RA_WIN0_BASE; regWrData = VAL_W0_WIDE;   end
      SEL_W1_CFG:     begin regWrAddr = RA_WIN1_BASE; regWrData = VAL_W1_CFG;    end
      SEL_W1_MAP_CFG: begin regWrAddr = RA_WIN1_MAP;  regWrData = 32'(mapReg);   end
      SEL_W1_PREF:    begin regWrAddr = RA_WIN1_BASE; regWrData = VAL_W1_PREF;   end
      SEL_W1_MAP_MEM: begin regWrAddr = RA_WIN1_MAP;  regWrData = 32'(VAL_MAP_MEM); end
      SEL_W0_NORMAL:  begin regWrAddr = RA_WIN0_BASE; regWrData = VAL_W0_NORMAL; end
      default:        begin regWrAddr = RA_WIN0_BASE; regWrData = '0;            end
    endcase
  end

  assign memAddr  = addrReg;
  assign memSize  = sizeReg;
  assign memWdata = wdataReg;
  assign rdData   = rdReg;

  // R1: the window-1 map write always carries the configuration type
  assert_map_cfg_type_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.regSel == SEL_W1_MAP_CFG) |-> (regWrData[3:1] == TYPE_CFG));

endmodule

// File: rtl/cfg_access_seq.sv
module cfg_access_seq
  import cfgseq_pkg::*;
#(
  parameter int IDX_W  = 9,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [IDX_W-1:0]  reqBus,
  input  logic [IDX_W-1:0]  reqDevfn,
  input  logic [IDX_W-1:0]  reqOffset,
  input  logic [2:0]        reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              busy,
  output logic              doneValid,
  output logic              errPulse,
  output logic [DATA_W-1:0] rdData,
  output logic              regWrEn,
  output logic [1:0]        regWrAddr,
  output logic [31:0]       regWrData,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [2:0]        memSize,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata
);

  dpStrobe_t strobe;
  logic      reqIllegal;

  cfgseq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqIllegal (reqIllegal),
    .memAck     (memAck),
    .strobe     (strobe),
    .regWrEn    (regWrEn),
    .memValid   (memValid),
    .memWrite   (memWrite),
    .busy       (busy),
    .reqReady   (reqReady),
    .doneValid  (doneValid),
    .errPulse   (errPulse)
  );

  cfgseq_dpath #(
    .IDX_W  (IDX_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .reqBus     (reqBus),
    .reqDevfn   (reqDevfn),
    .reqOffset  (reqOffset),
    .reqSize    (reqSize),
    .reqWdata   (reqWdata),
    .memRdata   (memRdata),
    .reqIllegal (reqIllegal),
    .regWrAddr  (regWrAddr),
    .regWrData  (regWrData),
    .memAddr    (memAddr),
    .memSize    (memSize),
    .memWdata   (memWdata),
    .rdData     (rdData)
  );

  // R9: a waiting access keeps its address and size
  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (memValid && !memAck) |=> (memValid && $stable(memAddr) && $stable(memSize)));

endmodule

// File: tb/cfg_access_seq_tb.sv
module cfg_access_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [8:0]  reqBus = '0;
  logic [8:0]  reqDevfn = '0;
  logic [8:0]  reqOffset = '0;
  logic [2:0]  reqSize = 3'd4;
  logic [31:0] reqWdata = '0;
  logic        busy, doneValid, errPulse;
  logic [31:0] rdData;
  logic        regWrEn;
  logic [1:0]  regWrAddr;
  logic [31:0] regWrData;
  logic        memValid, memWrite;
  logic [31:0] memAddr;
  logic [2:0]  memSize;
  logic [31:0] memWdata;
  logic        memAck = 1'b0;
  logic [31:0] memRdata = '0;

  int testsRun = 0;
  int testsFailed = 0;
  int ackDelay = 0;

  logic [1:0]  lRegA [16];
  logic [31:0] lRegD [16];
  int          nReg = 0;
  logic        lMemW [4];
  logic [31:0] lMemA [4];
  logic [2:0]  lMemS [4];
  logic [31:0] lMemD [4];
  int          nMem = 0;
  int          nBusyReady = 0;

  always #10 clk = ~clk;

  cfg_access_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqBus(reqBus), .reqDevfn(reqDevfn),
    .reqOffset(reqOffset), .reqSize(reqSize), .reqWdata(reqWdata),
    .busy(busy), .doneValid(doneValid), .errPulse(errPulse), .rdData(rdData),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
    .memSize(memSize), .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata)
  );

  // memory responder and activity log, both on the falling edge
  initial begin
    int waitCnt = 0;
    forever begin
      @(negedge clk);
      if (memValid) begin
        if (waitCnt >= ackDelay) begin
          memAck   = 1'b1;
          memRdata = memAddr ^ 32'h5A5A_0000;
          waitCnt  = 0;
        end else begin
          memAck  = 1'b0;
          waitCnt = waitCnt + 1;
        end
      end else begin
        memAck  = 1'b0;
        waitCnt = 0;
      end
      if (regWrEn && nReg < 16) begin
        lRegA[nReg] = regWrAddr;
        lRegD[nReg] = regWrData;
        nReg = nReg + 1;
      end
      if (memValid && memAck && nMem < 4) begin
        lMemW[nMem] = memWrite;
        lMemA[nMem] = memAddr;
        lMemS[nMem] = memSize;
        lMemD[nMem] = memWdata;
        nMem = nMem + 1;
      end
      if (busy && reqReady) nBusyReady = nBusyReady + 1;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    testsRun = testsRun + 1;
    if (act !== exp) begin
      testsFailed = testsFailed + 1;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expAddr(input logic [7:0] bus, input logic [7:0] devfn,
                                          input logic [7:0] off);
    logic [31:0] a;
    a = 32'h0;
    if (bus == 8'd0) begin
      a = {21'd0, devfn[2:0], 8'd0};
      if (devfn[7:3] <= 5'd12) a = a | (32'd1 << (devfn[7:3] + 11));
    end else begin
      a = {8'd0, bus, devfn, 8'd0};
    end
    return 32'h6100_0000 + a + {24'd0, off};
  endfunction

  function automatic logic [31:0] expMap(input logic [7:0] bus, input logic [7:0] devfn);
    logic [31:0] m;
    if (bus != 8'd0) m = 32'h0000_000B;
    else begin
      m = 32'h0000_000A;
      if (devfn[7:3] > 5'd12) m = m | ((32'd1 << (devfn[7:3] - 5)) & 32'h0000_FFFF);
    end
    return m;
  endfunction

  // one full request; checks sequence, addresses, data and done cycle
  task automatic runReq(input string req, input logic [7:0] bus, input logic [7:0] devfn,
                        input logic [7:0] off, input logic [2:0] size, input logic wr,
                        input logic [31:0] wdata);
    int cyc;
    int expCyc;
    logic [31:0] a;
    nReg = 0; nMem = 0; nBusyReady = 0;
    a = expAddr(bus, devfn, off);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqBus = {1'b0, bus}; reqDevfn = {1'b0, devfn};
    reqOffset = {1'b0, off}; reqSize = size; reqWdata = wdata;
    @(negedge clk);
    reqValid = 1'b0;
    cyc = 1;
    chk("R8", "busy after accept", {31'd0, busy}, 32'd1);
    while (!doneValid && cyc < 60) begin
      @(negedge clk);
      cyc = cyc + 1;
    end
    expCyc = wr ? (9 + 2 * ackDelay) : (8 + ackDelay);
    chk("R10", "done cycle", cyc, expCyc);
    chk("R10", "busy at done", {31'd0, busy}, 32'd0);
    chk("R8", "ready while busy", nBusyReady, 0);
    chk("R1", "reg write count", nReg, 6);
    chk("R1", "open0 addr", {30'd0, lRegA[0]}, 32'd0);
    chk("R1", "open0 data", lRegD[0], 32'h4000_0091);
    chk("R1", "open1 addr", {30'd0, lRegA[1]}, 32'd1);
    chk("R1", "open1 data", lRegD[1], 32'h6100_0041);
    chk("R1", "map addr", {30'd0, lRegA[2]}, 32'd2);
    chk(req, "map data", lRegD[2], expMap(bus, devfn));
    chk("R2", "close1 addr", {30'd0, lRegA[3]}, 32'd1);
    chk("R2", "close1 data", lRegD[3], 32'h5000_0089);
    chk("R2", "close2 addr", {30'd0, lRegA[4]}, 32'd2);
    chk("R2", "close2 data", lRegD[4], 32'h0000_100C);
    chk("R2", "close3 addr", {30'd0, lRegA[5]}, 32'd0);
    chk("R2", "close3 data", lRegD[5], 32'h4000_0081);
    chk("R6", "mem op count", nMem, wr ? 2 : 1);
    chk(req, "access addr", lMemA[0], a);
    chk("R9", "access size", {29'd0, lMemS[0]}, {29'd0, size});
    chk("R6", "access dir", {31'd0, lMemW[0]}, {31'd0, wr});
    if (wr) begin
      chk("R6", "write data", lMemD[0], wdata);
      chk("R6", "readback dir", {31'd0, lMemW[1]}, 32'd0);
      chk("R6", "readback addr", lMemA[1], a);
      chk("R6", "readback size", {29'd0, lMemS[1]}, {29'd0, size});
    end
    chk("R10", "rdData", rdData, a ^ 32'h5A5A_0000);
    @(negedge clk);
    chk("R10", "done one cycle", {31'd0, doneValid}, 32'd0);
  endtask

  task automatic testReset();
    chk("R11", "busy", {31'd0, busy}, 32'd0);
    chk("R11", "reqReady", {31'd0, reqReady}, 32'd1);
    chk("R11", "doneValid", {31'd0, doneValid}, 32'd0);
    chk("R11", "errPulse", {31'd0, errPulse}, 32'd0);
    chk("R11", "regWrEn", {31'd0, regWrEn}, 32'd0);
    chk("R11", "memValid", {31'd0, memValid}, 32'd0);
  endtask

  task automatic testIllegal(input logic [8:0] bus, input logic [8:0] devfn,
                             input logic [8:0] off);
    nReg = 0; nMem = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqBus = bus; reqDevfn = devfn; reqOffset = off;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R7", "errPulse", {31'd0, errPulse}, 32'd1);
    chk("R7", "busy", {31'd0, busy}, 32'd0);
    for (int i = 0; i < 6; i++) @(negedge clk);
    chk("R7", "no reg writes", nReg, 0);
    chk("R7", "no mem ops", nMem, 0);
    chk("R7", "error one cycle", {31'd0, errPulse}, 32'd0);
  endtask

  task automatic testStall();
    int cyc;
    nReg = 0; nMem = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqBus = 9'd0; reqDevfn = 9'h48; reqOffset = 9'd0;
    reqSize = 3'd4;
    @(negedge clk);
    cyc = 1;
    while (!doneValid && cyc < 60) begin
      @(negedge clk);
      cyc = cyc + 1;
    end
    chk("R8", "writes before first done", nReg, 6);
    chk("R8", "ready at done", {31'd0, reqReady}, 32'd1);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R8", "held request accepted", {31'd0, busy}, 32'd1);
    cyc = 0;
    while (!doneValid && cyc < 60) begin
      @(negedge clk);
      cyc = cyc + 1;
    end
    chk("R8", "writes after second done", nReg, 12);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed = testsFailed + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    runReq("R3", 8'd0, {5'd9, 3'd2}, 8'h10, 3'd4, 1'b0, 32'h0);
    runReq("R3", 8'd0, {5'd12, 3'd0}, 8'h04, 3'd2, 1'b1, 32'h0000_1234);
    runReq("R4", 8'd0, {5'd15, 3'd1}, 8'h3C, 3'd1, 1'b0, 32'h0);
    runReq("R4", 8'd0, {5'd24, 3'd3}, 8'h00, 3'd4, 1'b0, 32'h0);
    runReq("R5", 8'd3, 8'h4B, 8'h08, 3'd2, 1'b0, 32'h0);
    runReq("R5", 8'd255, 8'hFF, 8'hFC, 3'd4, 1'b1, 32'hDEAD_BEEF);
    ackDelay = 2;
    runReq("R9", 8'd0, {5'd13, 3'd7}, 8'h20, 3'd4, 1'b1, 32'hCAFE_0001);
    runReq("R9", 8'd7, 8'h10, 8'hFF, 3'd1, 1'b0, 32'h0);
    ackDelay = 0;
    testIllegal(9'd256, 9'd0, 9'd0);
    testIllegal(9'd0, 9'd300, 9'd0);
    testIllegal(9'd1, 9'd8, 9'd256);
    testStall();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule